// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block is a hardware sequencer that sets the output impedance of a memory interface driver. It works on two legs, one after the other: the pull-up leg first, then the pull-down leg. For each leg it turns on the calibration pad, waits a fixed number of cycles for the external comparator to settle, and samples the comparator bit. A 1 moves the leg to the next entry of an ordered list of 4-bit impedance codes, which runs from highest to lowest impedance, and the wait starts again. A 0 locks the current code. The list has 14 entries for 1.8 V memories and 10 entries for 1.5 V memories. The 10 entries of the 1.5 V list are also the first 10 entries of the 1.8 V list.

A start pulse begins a run. The mode and the calibration-enable input are captured at the start pulse. When calibration is disabled, no pad is enabled and both legs are loaded at once with the half-strength code for the selected mode. If the comparator still reads 1 at the last entry of the list, the leg keeps that last entry, its fail bit is set, and the sequence carries on. A one-cycle done pulse marks the end of every run.

Top module: `drv_imp_cal_seq`

## Requirements
- R1: After reset both output enables, both codes, done and both fail bits are 0.
- R2: A start with calibration disabled loads both codes with the half-strength value (4'b1111 when mode_i=0 for 1.8 V, 4'b0000 when mode_i=1 for 1.5 V) and clears both fail bits. No output enable is asserted, and done is high in the cycle after the start edge.
- R3: Each leg starts at index 0 and steps through the code list in index order. The full list (mode 0) is, from index 0: 0,1,3,2,6,7,5,4,C,D,E,A,B,9 in hex. Mode 1 uses only indices 0 to 9 of that list.
- R4: The comparator is sampled exactly SETTLE_CYCLES clock edges after the leg's output enable rises or after its code changes, and never earlier.
- R5: A sampled comparator value of 1 moves the leg to the next index. A sampled 0 locks the current code, and the leg's code then holds until the next start.
- R6: The pull-up leg runs first and its output enable is asserted at the start edge. On the edge where the pull-up code locks, pu_oe_o falls. pd_oe_o rises one edge later, with the pull-down code at 4'b0000.
- R7: On the edge where the pull-down code locks, pd_oe_o falls. done_o is high for exactly the following cycle and is never high while an output enable is asserted.
- R8: If the comparator reads 1 at the last index for the active mode, the leg keeps the last code and its fail bit is set (fail_o[0] for pull-up, fail_o[1] for pull-down). The sequence then continues. Fail bits hold until the next accepted start.
- R9: A start pulse that arrives while a run is in progress, including the done cycle, is ignored.
- R10: The two output enables are never asserted in the same cycle.
- R11: mode_i and cal_en_i are sampled only at an accepted start edge. Changing them during a run does not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| mode_i | input | 1 | 0 = 1.8 V list and defaults, 1 = 1.5 V list and defaults |
| cal_en_i | input | 1 | 1 = run the search, 0 = load half-strength defaults |
| cmp_i | input | 1 | Comparator result for the pad that is enabled |
| pu_oe_o | output | 1 | Pull-up calibration pad enable |
| pd_oe_o | output | 1 | Pull-down calibration pad enable |
| pu_code_o | output | CODE_W | Pull-up impedance code |
| pd_code_o | output | CODE_W | Pull-down impedance code |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 2 | Per-leg fail bits: bit 0 pull-up, bit 1 pull-down |

## Verification
The checker watches several properties on every cycle. The two enables must never overlap. Done must be a single cycle with both pads off. The pull-down pad must follow the pull-up release after exactly one edge, starting at code 0. A fail bit may rise only as its leg releases. Counters in the checker also measure that no code change and no release happens fewer than SETTLE_CYCLES edges after the previous one. The exact code order, the lock position for each comparator outcome, the half-strength defaults, and the fact that mid-run starts and mode changes have no effect can only be shown by the bench's sweeps. Those sweeps compare every cycle of each run against a timeline computed in the bench.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

   localparam int LADDER_LEN  = 14;
   localparam int LADDER_V15  = 10;
   localparam int LADDER_IDXW = $clog2(LADDER_LEN);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PU_SETTLE,
      ST_HANDOFF,
      ST_PD_SETTLE,
      ST_FINISH
   } cal_state_e;

   typedef enum logic {
      MODE_V18 = 1'b0,
      MODE_V15 = 1'b1
   } volt_mode_e;

   localparam int LEG_PU = 0;
   localparam int LEG_PD = 1;
   localparam int N_LEGS = 2;

   // Impedance ladder, highest impedance first; the 1.5 V ladder is a prefix.
   function automatic logic [3:0] ladder_entry(input logic [LADDER_IDXW-1:0] idx);
      logic [3:0] c;
      case (idx)
         4'd0:    c = 4'h0;
         4'd1:    c = 4'h1;
         4'd2:    c = 4'h3;
         4'd3:    c = 4'h2;
         4'd4:    c = 4'h6;
         4'd5:    c = 4'h7;
         4'd6:    c = 4'h5;
         4'd7:    c = 4'h4;
         4'd8:    c = 4'hC;
         4'd9:    c = 4'hD;
         4'd10:   c = 4'hE;
         4'd11:   c = 4'hA;
         4'd12:   c = 4'hB;
         4'd13:   c = 4'h9;
         default: c = 4'h9;
      endcase
      return c;
   endfunction

   function automatic logic [LADDER_IDXW-1:0] ladder_last(input volt_mode_e m);
      return (m == MODE_V15) ? LADDER_IDXW'(LADDER_V15 - 1)
                             : LADDER_IDXW'(LADDER_LEN - 1);
   endfunction

   function automatic logic [3:0] half_strength(input volt_mode_e m);
      return (m == MODE_V15) ? 4'h0 : 4'hF;
   endfunction

endpackage

// File: rtl/imp_code_table.sv
module imp_code_table
   import imp_cal_pkg::*;
#(
   parameter int CODE_W = 4,
   parameter int IDX_W  = LADDER_IDXW
) (
   input  volt_mode_e        mode_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [CODE_W-1:0] code_o,
   output logic [IDX_W-1:0]  last_o
);

   if (CODE_W != 4) begin : g_bad_width
      $error("imp_code_table: ladder entries are 4 bits wide");
   end
   if (IDX_W < LADDER_IDXW) begin : g_bad_idx
      $error("imp_code_table: index too narrow for the ladder");
   end

   logic [LADDER_IDXW-1:0] idx_n;
   assign idx_n = idx_i[LADDER_IDXW-1:0];

   assign code_o = CODE_W'(ladder_entry(idx_n));
   assign last_o = IDX_W'(ladder_last(mode_i));

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int SETTLE_CYCLES = 4,
   localparam int TW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic run_i,
   output logic expired_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart_i)  cnt_q <= '0;
      else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q == TW'(SETTLE_CYCLES - 1));

endmodule

// File: rtl/cal_leg_reg.sv
module cal_leg_reg #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic [CODE_W-1:0] init_code_i,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              oe_set_i,
   input  logic              oe_clr_i,
   input  logic              fail_set_i,
   output logic [CODE_W-1:0] code_o,
   output logic              oe_o,
   output logic              fail_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         fail_o <= 1'b0;
      end else if (init_i) begin
         code_o <= init_code_i;
         fail_o <= 1'b0;
      end else begin
         if (load_i)     code_o <= code_i;
         if (fail_set_i) fail_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        oe_o <= 1'b0;
      else if (oe_set_i) oe_o <= 1'b1;
      else if (oe_clr_i) oe_o <= 1'b0;
   end

endmodule

// File: rtl/drv_imp_cal_seq.sv
module drv_imp_cal_seq
   import imp_cal_pkg::*;
#(
   parameter int CODE_W        = 4,
   parameter int SETTLE_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic              cal_en_i,
   input  logic              cmp_i,
   output logic              pu_oe_o,
   output logic              pd_oe_o,
   output logic [CODE_W-1:0] pu_code_o,
   output logic [CODE_W-1:0] pd_code_o,
   output logic              done_o,
   output logic [1:0]        fail_o
);

   localparam int IDX_W = LADDER_IDXW;

   if (SETTLE_CYCLES < 4) begin : g_bad_settle
      $error("drv_imp_cal_seq: SETTLE_CYCLES must be at least 4");
   end
   if (CODE_W != 4) begin : g_bad_code
      $error("drv_imp_cal_seq: CODE_W must be 4");
   end

   cal_state_e        state_q, state_d;
   volt_mode_e        mode_q;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [IDX_W-1:0]  tbl_idx, last_idx;
   logic [CODE_W-1:0] tbl_code, init_code;
   logic              tmr_restart, tmr_run, tmr_expired;
   logic              accept, leg_init;
   logic              active_pd, at_last;

   logic [N_LEGS-1:0]              leg_load, leg_oe_set, leg_oe_clr, leg_fail_set;
   logic [N_LEGS-1:0]              leg_oe, leg_fail;
   logic [N_LEGS-1:0][CODE_W-1:0]  leg_code;

   assign accept = (state_q == ST_IDLE) && start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_V18;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         if (accept) mode_q <= volt_mode_e'(mode_i);
      end
   end

   imp_code_table #(
      .CODE_W (CODE_W),
      .IDX_W  (IDX_W)
   ) u_table (
      .mode_i (mode_q),
      .idx_i  (tbl_idx),
      .code_o (tbl_code),
      .last_o (last_idx)
   );

   settle_timer #(
      .SETTLE_CYCLES (SETTLE_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (tmr_restart),
      .run_i     (tmr_run),
      .expired_o (tmr_expired)
   );

   assign active_pd = (state_q == ST_PD_SETTLE);
   assign tmr_run   = (state_q == ST_PU_SETTLE) || active_pd;
   assign at_last   = (idx_q == last_idx);
   assign init_code = cal_en_i ? '0 : CODE_W'(half_strength(volt_mode_e'(mode_i)));
   assign leg_init  = accept;

   always_comb begin
      state_d      = state_q;
      idx_d        = idx_q;
      tbl_idx      = idx_q + 1'b1;
      tmr_restart  = 1'b0;
      leg_load     = '0;
      leg_oe_set   = '0;
      leg_oe_clr   = '0;
      leg_fail_set = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               idx_d = '0;
               if (cal_en_i) begin
                  leg_oe_set[LEG_PU] = 1'b1;
                  tmr_restart        = 1'b1;
                  state_d            = ST_PU_SETTLE;
               end else begin
                  state_d = ST_FINISH;
               end
            end
         end
         ST_PU_SETTLE, ST_PD_SETTLE: begin
            if (tmr_expired) begin
               if (cmp_i && !at_last) begin
                  idx_d                           = idx_q + 1'b1;
                  leg_load[active_pd ? 1 : 0]     = 1'b1;
                  tmr_restart                     = 1'b1;
               end else begin
                  leg_fail_set[active_pd ? 1 : 0] = cmp_i;
                  leg_oe_clr[active_pd ? 1 : 0]   = 1'b1;
                  state_d = active_pd ? ST_FINISH : ST_HANDOFF;
               end
            end
         end
         ST_HANDOFF: begin
            tbl_idx            = '0;
            idx_d              = '0;
            leg_load[LEG_PD]   = 1'b1;
            leg_oe_set[LEG_PD] = 1'b1;
            tmr_restart        = 1'b1;
            state_d            = ST_PD_SETTLE;
         end
         ST_FINISH: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
      cal_leg_reg #(
         .CODE_W (CODE_W)
      ) u_leg (
         .clk         (clk),
         .rst_n       (rst_n),
         .init_i      (leg_init),
         .init_code_i (init_code),
         .load_i      (leg_load[g]),
         .code_i      (tbl_code),
         .oe_set_i    (leg_oe_set[g]),
         .oe_clr_i    (leg_oe_clr[g]),
         .fail_set_i  (leg_fail_set[g]),
         .code_o      (leg_code[g]),
         .oe_o        (leg_oe[g]),
         .fail_o      (leg_fail[g])
      );
   end

   assign pu_oe_o   = leg_oe[LEG_PU];
   assign pd_oe_o   = leg_oe[LEG_PD];
   assign pu_code_o = leg_code[LEG_PU];
   assign pd_code_o = leg_code[LEG_PD];
   assign fail_o    = leg_fail;
   assign done_o    = (state_q == ST_FINISH);

endmodule

// File: rtl/imp_cal_checker.sv
module imp_cal_checker #(
   parameter int CODE_W        = 4,
   parameter int SETTLE_CYCLES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pu_oe,
   input logic              pd_oe,
   input logic [CODE_W-1:0] pu_code,
   input logic [CODE_W-1:0] pd_code,
   input logic              done,
   input logic [1:0]        fail
);

   logic              pu_oe_p, pd_oe_p;
   logic [CODE_W-1:0] pu_code_p, pd_code_p;
   logic [15:0]       pu_since, pd_since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pu_oe_p   <= 1'b0;
         pd_oe_p   <= 1'b0;
         pu_code_p <= '0;
         pd_code_p <= '0;
         pu_since  <= '0;
         pd_since  <= '0;
      end else begin
         pu_oe_p   <= pu_oe;
         pd_oe_p   <= pd_oe;
         pu_code_p <= pu_code;
         pd_code_p <= pd_code;
         if ((pu_oe && !pu_oe_p) || (pu_code != pu_code_p)) pu_since <= '0;
         else if (pu_since != 16'hFFFF)                      pu_since <= pu_since + 1'b1;
         if ((pd_oe && !pd_oe_p) || (pd_code != pd_code_p)) pd_since <= '0;
         else if (pd_since != 16'hFFFF)                      pd_since <= pd_since + 1'b1;
      end
   end

   assert_oe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pu_oe && pd_oe));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_pads_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!pu_oe && !pd_oe));

   assert_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pu_oe) |=> (pd_oe && pd_code == '0));

   assert_pu_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pu_oe |-> (pu_code != CODE_W'(4'hF) && pu_code != CODE_W'(4'h8)));

   assert_pd_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pd_oe |-> (pd_code != CODE_W'(4'hF) && pd_code != CODE_W'(4'h8)));

   assert_pu_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pu_oe && pu_oe_p && pu_code != pu_code_p) || (!pu_oe && pu_oe_p))
      |-> (pu_since >= 16'(SETTLE_CYCLES - 1)));

   assert_pd_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pd_oe && pd_oe_p && pd_code != pd_code_p) || (!pd_oe && pd_oe_p))
      |-> (pd_since >= 16'(SETTLE_CYCLES - 1)));

   assert_pu_fail_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail[0]) |-> $fell(pu_oe));

   assert_pd_fail_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail[1]) |-> $fell(pd_oe));

endmodule

bind drv_imp_cal_seq imp_cal_checker #(
   .CODE_W        (CODE_W),
   .SETTLE_CYCLES (SETTLE_CYCLES)
) u_imp_cal_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .pu_oe   (pu_oe_o),
   .pd_oe   (pd_oe_o),
   .pu_code (pu_code_o),
   .pd_code (pd_code_o),
   .done    (done_o),
   .fail    (fail_o)
);

// File: tb/tb_drv_imp_cal_seq.sv
`timescale 1ns/1ps
module tb_drv_imp_cal_seq;

   localparam int W = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       mode_i = 1'b0;
   logic       cal_en_i = 1'b1;
   logic       cmp_i;
   logic       pu_oe_o, pd_oe_o, done_o;
   logic [3:0] pu_code_o, pd_code_o;
   logic [1:0] fail_o;

   int checks = 0;
   int errors = 0;
   int tgt_pu = 0;
   int tgt_pd = 0;
   logic run_mode = 1'b0;

   always #10 clk = ~clk;

   drv_imp_cal_seq #(.CODE_W(4), .SETTLE_CYCLES(W)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .cal_en_i(cal_en_i), .cmp_i(cmp_i), .pu_oe_o(pu_oe_o), .pd_oe_o(pd_oe_o),
      .pu_code_o(pu_code_o), .pd_code_o(pd_code_o), .done_o(done_o), .fail_o(fail_o)
   );

   function automatic logic [3:0] ref_code(input int i);
      logic [3:0] t [14] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5,
                             4'h4, 4'hC, 4'hD, 4'hE, 4'hA, 4'hB, 4'h9};
      return (i >= 0 && i < 14) ? t[i] : 4'h8;
   endfunction

   function automatic int ref_last(input logic m);
      return m ? 9 : 13;
   endfunction

   // Comparator model: reads 1 until the target entry is on the pad.
   always_comb begin
      if (pu_oe_o)      cmp_i = (tgt_pu > ref_last(run_mode)) ? 1'b1 : (pu_code_o != ref_code(tgt_pu));
      else if (pd_oe_o) cmp_i = (tgt_pd > ref_last(run_mode)) ? 1'b1 : (pd_code_o != ref_code(tgt_pd));
      else              cmp_i = 1'b0;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // One calibrated run with per-cycle comparison; disturb pulses start and flips inputs mid-run.
   task automatic run_cal(input logic m, input int tp, input int td, input bit disturb);
      int lp, ld, lpu, lpd, last;
      logic [3:0] epu, epd;
      logic [1:0] efail;
      last = ref_last(m);
      lp = (tp > last) ? last : tp;
      ld = (td > last) ? last : td;
      lpu = W * (lp + 1);
      lpd = W * (ld + 1);
      tgt_pu = tp; tgt_pd = td; run_mode = m;
      mode_i = m; cal_en_i = 1'b1; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int j = 0; j <= lpu + ld * 0 + lpd + 1; j++) begin
         logic [10:0] act, exp;
         if (j > 0) begin @(posedge clk); @(negedge clk); end
         if (disturb && j == 2) begin
            start_i = 1'b1; mode_i = ~m; cal_en_i = 1'b0;
         end else if (disturb && j == 3) begin
            start_i = 1'b0;
         end
         if (disturb && j == lpu + lpd + 1) start_i = 1'b1;
         if (j < lpu) begin
            epu = ref_code(j / W); epd = 4'h0;
            exp = {1'b1, 1'b0, epu, epd, 1'b0};
         end else if (j == lpu) begin
            exp = {1'b0, 1'b0, ref_code(lp), 4'h0, 1'b0};
         end else if (j <= lpu + lpd) begin
            exp = {1'b0, 1'b1, ref_code(lp), ref_code((j - lpu - 1) / W), 1'b0};
         end else begin
            exp = {1'b0, 1'b0, ref_code(lp), ref_code(ld), 1'b1};
         end
         act = {pu_oe_o, pd_oe_o, pu_code_o, pd_code_o, done_o};
         chk(act == exp, disturb ? "R9 R11 busy start/mode ignored" : "R3 R4 R5 R6 R7 sequence",
             32'(act), 32'(exp));
      end
      efail = {(td > last), (tp > last)};
      chk(fail_o == efail, "R8 fail bits", 32'(fail_o), 32'(efail));
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R7 done one cycle / R9 start in done ignored", 32'(done_o), 32'd0);
      chk(pu_code_o == ref_code(lp) && pd_code_o == ref_code(ld), "R5 codes hold after lock",
          32'({pu_code_o, pd_code_o}), 32'({ref_code(lp), ref_code(ld)}));
      mode_i = 1'b0; cal_en_i = 1'b1;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic run_default(input logic m);
      logic [3:0] h;
      h = m ? 4'h0 : 4'hF;
      mode_i = m; cal_en_i = 1'b0; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0; mode_i = ~m;
      chk(done_o == 1'b1 && !pu_oe_o && !pd_oe_o, "R2 done without pads",
          32'({done_o, pu_oe_o, pd_oe_o}), 32'(3'b100));
      chk(pu_code_o == h && pd_code_o == h && fail_o == 2'b00, "R2 half-strength codes",
          32'({fail_o, pu_code_o, pd_code_o}), 32'({2'b00, h, h}));
      @(posedge clk); @(negedge clk);
      chk(done_o == 1'b0, "R2 done single cycle", 32'(done_o), 32'd0);
      mode_i = 1'b0; cal_en_i = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog R7 done not reached act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
   end

   initial begin
      #1;
      chk({pu_oe_o, pd_oe_o, pu_code_o, pd_code_o, done_o, fail_o} == '0, "R1 reset state",
          32'({pu_oe_o, pd_oe_o, pu_code_o, pd_code_o, done_o, fail_o}), 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({pu_oe_o, pd_oe_o, done_o} == '0, "R1 idle after reset",
          32'({pu_oe_o, pd_oe_o, done_o}), 32'd0);

      run_default(1'b0);
      run_default(1'b1);

      for (int m = 0; m < 2; m++) begin
         for (int tp = 0; tp <= ref_last(m[0]) + 1; tp++) begin
            run_cal(m[0], tp, 0, 1'b0);
            run_cal(m[0], tp, ref_last(m[0]), 1'b0);
            run_cal(m[0], tp, ref_last(m[0]) + 1, tp == 3);
            run_cal(m[0], tp, (tp * 5) % (ref_last(m[0]) + 1), tp == 1);
         end
      end

      // Fail bits clear at the next accepted start (R8), also via defaults (R2).
      run_cal(1'b1, 20, 20, 1'b0);
      run_default(1'b0);
      chk(fail_o == 2'b00, "R8 fail cleared by start", 32'(fail_o), 32'd0);

      summary();
      $finish;
   end

endmodule